// File: doc/BRIEF.md
# Lookahead Mesh Route Computation

This block sits in the input port of a router in a two-dimensional mesh. It computes routes one hop ahead. A head flit arrives already carrying the output port it must take at this router, so the block forwards that port without evaluating any routing function for it. In parallel, the block works out the port the flit will need at the next router, which is the neighbour reached through the carried port. That result is registered into the outgoing head flit's next-hop field.

Two routing disciplines can be selected per flit. The first is dimension-ordered routing: all of the X offset is corrected before any of the Y offset. The second is a west-first adaptive scheme. In that scheme any westward travel comes first, and after that the block picks between the remaining minimal directions using per-direction congestion hints. Route computation happens once per packet. Body and tail flits are tagged with the ports that were recorded for their head. The mesh size, this router's position and the hint width are all parameters.

Top module: `lookahead_route`

## Requirements
- R1: After reset `outValid` is 0 and no packet is open, so a non-head flit arriving first produces no output.
- R2: A head flit presented with `inValid`=1 appears one clock later with `outValid`=1, `outHead`=1 and `outPort` equal to the port it carried. Port codes are: local 0, north 1, east 2, south 3, west 4.
- R3: Body and tail flits of an open packet appear one clock later carrying the head's `outPort` and `outNextPort`. A tail, or a head flagged as tail, closes the packet. A non-head flit with no packet open is dropped.
- R4: The next-hop route is evaluated at the neighbour that the carried port leads to. North is +1 in Y, south is -1 in Y, east is +1 in X and west is -1 in X. When that neighbour is the destination, the next-hop port is local.
- R5: With `routeMode`=0 (dimension order), the next-hop port is east or west while the X coordinates differ. Otherwise it is north or south while the Y coordinates differ.
- R6: With `routeMode`=1 (west-first), the next-hop port is west whenever the destination X is below the neighbour's X.
- R7: In west-first mode, when both east and one Y direction are minimal, the direction whose hint is lower is chosen, and ties go to east. Hint slot k (bits k*HINT_W upward) belongs to port code k+1.
- R8: A head flit carrying the local port gets a local next-hop port.
- R9: The next-hop port is never the reverse of the carried port, and it is always a minimal direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Flit present this cycle |
| inHead | input | 1 | Flit is a head |
| inTail | input | 1 | Flit is a tail |
| routeMode | input | 1 | 0 dimension order, 1 west-first adaptive |
| destX | input | XW | Destination column of the packet |
| destY | input | YW | Destination row of the packet |
| inPort | input | 3 | Port precomputed for this router |
| congHint | input | 4*HINT_W | Congestion hints for the neighbour's N, E, S, W outputs |
| outValid | output | 1 | Flit leaving the stage |
| outHead | output | 1 | Outgoing flit is a head |
| outTail | output | 1 | Outgoing flit is a tail |
| outPort | output | 3 | Port to use at this router |
| outNextPort | output | 3 | Port to use at the next router |

## Verification
The assertions assume that the port carried by a head flit is itself legal. It must be a minimal direction from this router toward the destination, and it must also obey the selected discipline: in dimension order it must be X before Y, and in west-first it must be west whenever the destination lies west. Under that assumption the neighbour always lies inside the mesh. The turn and reversal properties can then be checked against the carried port. The stimulus sweeps every destination in a 4x4 mesh and feeds only those carried ports that a legal upstream router could have chosen. For each of these it applies hint patterns that favour X, favour Y, or tie.

// File: rtl/lr_pkg.sv
package lr_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } portT;

  typedef struct packed {
    logic loadHead;
    logic loadBody;
  } strobeT;

  function automatic portT reversePort(portT p);
    case (p)
      PORT_NORTH: reversePort = PORT_SOUTH;
      PORT_SOUTH: reversePort = PORT_NORTH;
      PORT_EAST:  reversePort = PORT_WEST;
      PORT_WEST:  reversePort = PORT_EAST;
      default:    reversePort = PORT_LOCAL;
    endcase
  endfunction

endpackage

// File: rtl/lr_ctrl.sv
module lr_ctrl
  import lr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inHead,
  input  logic   inTail,
  output strobeT strobe,
  output logic   outValid,
  output logic   outHead,
  output logic   outTail
);

  logic pktOpen;

  always_comb begin
    strobe.loadHead = inValid && inHead;
    strobe.loadBody = inValid && !inHead && pktOpen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktOpen  <= 1'b0;
      outValid <= 1'b0;
      outHead  <= 1'b0;
      outTail  <= 1'b0;
    end else begin
      if (strobe.loadHead)
        pktOpen <= !inTail;
      else if (strobe.loadBody && inTail)
        pktOpen <= 1'b0;
      outValid <= strobe.loadHead || strobe.loadBody;
      outHead  <= strobe.loadHead;
      outTail  <= (strobe.loadHead || strobe.loadBody) && inTail;
    end
  end

  // A flit that is neither a head nor part of an open packet never reaches the output.
  assert_orphan_dropped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inHead && !pktOpen) |=> !outValid);

  // Once a tail has been sent, no flit can follow it except a new head.
  assert_after_tail_only_head_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTail) |=> (!outValid || outHead));

  assert_flags_need_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outHead && !outTail));

endmodule

// File: rtl/lr_datapath.sv
module lr_datapath
  import lr_pkg::*;
#(
  parameter int MESH_X   = 4,
  parameter int MESH_Y   = 4,
  parameter int ROUTER_X = 1,
  parameter int ROUTER_Y = 2,
  parameter int HINT_W   = 4,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              outValid,
  input  logic              outHead,
  input  logic              routeMode,
  input  logic [XW-1:0]     destX,
  input  logic [YW-1:0]     destY,
  input  logic [2:0]        inPort,
  input  logic [4*HINT_W-1:0] congHint,
  output logic [2:0]        outPort,
  output logic [2:0]        outNextPort
);

  localparam logic [XW:0] HERE_X = (XW+1)'(ROUTER_X);
  localparam logic [YW:0] HERE_Y = (YW+1)'(ROUTER_Y);

  portT            curPort;
  logic [XW:0]     nbrX;
  logic [YW:0]     nbrY;
  logic [XW:0]     dstX;
  logic [YW:0]     dstY;
  logic            xGt, xLt, yGt, yLt;
  portT            yDir;
  logic [HINT_W-1:0] hintEast, hintY;
  portT            xyPort, wfPort, routed;
  portT            portQ, nextQ;

  assign curPort = portT'(inPort);
  assign dstX    = {1'b0, destX};
  assign dstY    = {1'b0, destY};

  // Coordinates of the router that the carried port leads to.
  always_comb begin
    nbrX = HERE_X;
    nbrY = HERE_Y;
    case (curPort)
      PORT_NORTH: nbrY = HERE_Y + 1'b1;
      PORT_SOUTH: nbrY = HERE_Y - 1'b1;
      PORT_EAST:  nbrX = HERE_X + 1'b1;
      PORT_WEST:  nbrX = HERE_X - 1'b1;
      default: ;
    endcase
  end

  assign xGt  = dstX > nbrX;
  assign xLt  = dstX < nbrX;
  assign yGt  = dstY > nbrY;
  assign yLt  = dstY < nbrY;
  assign yDir = yGt ? PORT_NORTH : PORT_SOUTH;

  // Hint lookup: slot k holds port code k+1.
  always_comb begin
    hintEast = congHint[1*HINT_W +: HINT_W];
    hintY    = yGt ? congHint[0*HINT_W +: HINT_W] : congHint[2*HINT_W +: HINT_W];
  end

  // Dimension-ordered function evaluated at the neighbour.
  always_comb begin
    if (xGt)      xyPort = PORT_EAST;
    else if (xLt) xyPort = PORT_WEST;
    else if (yGt) xyPort = PORT_NORTH;
    else if (yLt) xyPort = PORT_SOUTH;
    else          xyPort = PORT_LOCAL;
  end

  // West-first function evaluated at the neighbour.
  always_comb begin
    if (xLt)
      wfPort = PORT_WEST;
    else if (xGt && (yGt || yLt))
      wfPort = (hintY < hintEast) ? yDir : PORT_EAST;
    else if (xGt) wfPort = PORT_EAST;
    else if (yGt) wfPort = PORT_NORTH;
    else if (yLt) wfPort = PORT_SOUTH;
    else          wfPort = PORT_LOCAL;
  end

  always_comb begin
    if (curPort == PORT_LOCAL) routed = PORT_LOCAL;
    else if (routeMode)        routed = wfPort;
    else                       routed = xyPort;
  end

  // Body and tail flits leave the recorded ports untouched.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portQ <= PORT_LOCAL;
      nextQ <= PORT_LOCAL;
    end else if (strobe.loadHead) begin
      portQ <= curPort;
      nextQ <= routed;
    end
  end

  assign outPort     = portQ;
  assign outNextPort = nextQ;

  assert_head_port_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHead |=> (outPort == $past(inPort)));

  assert_body_keeps_ports_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHead && $past(outValid)) |->
      (outPort == $past(outPort) && outNextPort == $past(outNextPort)));

  assert_xy_no_y_to_x_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadHead && !routeMode && (curPort == PORT_NORTH || curPort == PORT_SOUTH))
      |-> (routed == curPort || routed == PORT_LOCAL));

  assert_wf_no_turn_into_west_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadHead && routeMode && routed == PORT_WEST)
      |-> (curPort == PORT_WEST));

  assert_no_reversal_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHead && outPort != PORT_LOCAL)
      |-> (outNextPort != reversePort(portT'(outPort))));

  assert_local_stays_local_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHead && outPort == PORT_LOCAL) |-> (outNextPort == PORT_LOCAL));

endmodule

// File: rtl/lookahead_route.sv
module lookahead_route
  import lr_pkg::*;
#(
  parameter int MESH_X   = 4,
  parameter int MESH_Y   = 4,
  parameter int ROUTER_X = 1,
  parameter int ROUTER_Y = 2,
  parameter int HINT_W   = 4,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inHead,
  input  logic                inTail,
  input  logic                routeMode,
  input  logic [XW-1:0]       destX,
  input  logic [YW-1:0]       destY,
  input  logic [2:0]          inPort,
  input  logic [4*HINT_W-1:0] congHint,
  output logic                outValid,
  output logic                outHead,
  output logic                outTail,
  output logic [2:0]          outPort,
  output logic [2:0]          outNextPort
);

  strobeT strobe;

  lr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inHead   (inHead),
    .inTail   (inTail),
    .strobe   (strobe),
    .outValid (outValid),
    .outHead  (outHead),
    .outTail  (outTail)
  );

  lr_datapath #(
    .MESH_X   (MESH_X),
    .MESH_Y   (MESH_Y),
    .ROUTER_X (ROUTER_X),
    .ROUTER_Y (ROUTER_Y),
    .HINT_W   (HINT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .outValid    (outValid),
    .outHead     (outHead),
    .routeMode   (routeMode),
    .destX       (destX),
    .destY       (destY),
    .inPort      (inPort),
    .congHint    (congHint),
    .outPort     (outPort),
    .outNextPort (outNextPort)
  );

endmodule

// File: tb/lookahead_route_tb.sv
module lookahead_route_tb;

  localparam int MX = 4, MY = 4, RX = 1, RY = 2, HW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inHead = 1'b0, inTail = 1'b0, routeMode = 1'b0;
  logic [1:0] destX = '0, destY = '0;
  logic [2:0] inPort = '0;
  logic [4*HW-1:0] congHint = '0;
  logic outValid, outHead, outTail;
  logic [2:0] outPort, outNextPort;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lookahead_route #(.MESH_X(MX), .MESH_Y(MY), .ROUTER_X(RX), .ROUTER_Y(RY), .HINT_W(HW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHead(inHead), .inTail(inTail),
    .routeMode(routeMode), .destX(destX), .destY(destY), .inPort(inPort),
    .congHint(congHint), .outValid(outValid), .outHead(outHead), .outTail(outTail),
    .outPort(outPort), .outNextPort(outNextPort));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int oppositeOf(int p);
    case (p)
      1: return 3;
      3: return 1;
      2: return 4;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int hintAt(logic [4*HW-1:0] h, int p);
    return int'(h[(p-1)*HW +: HW]);
  endfunction

  // Expected next-hop port from the requirements.
  function automatic int expectNext(int mode, int dx, int dy, int p, logic [4*HW-1:0] h);
    int nx = RX, ny = RY, yd;
    if (p == 0) return 0;
    if (p == 1) ny = RY + 1;
    if (p == 3) ny = RY - 1;
    if (p == 2) nx = RX + 1;
    if (p == 4) nx = RX - 1;
    if (mode == 0) begin
      if (dx > nx) return 2;
      if (dx < nx) return 4;
      if (dy > ny) return 1;
      if (dy < ny) return 3;
      return 0;
    end
    if (dx < nx) return 4;
    if (dx > nx && dy != ny) begin
      yd = (dy > ny) ? 1 : 3;
      return (hintAt(h, yd) < hintAt(h, 2)) ? yd : 2;
    end
    if (dx > nx) return 2;
    if (dy > ny) return 1;
    if (dy < ny) return 3;
    return 0;
  endfunction

  // Whether an upstream router could legally have chosen port p here.
  function automatic bit legalPort(int mode, int dx, int dy, int p);
    bit e = dx > RX, w = dx < RX, n = dy > RY, s = dy < RY;
    if (p == 0) return !e && !w && !n && !s;
    if (mode == 0) begin
      if (e || w) return (p == 2 && e) || (p == 4 && w);
      return (p == 1 && n) || (p == 3 && s);
    end
    if (w) return p == 4;
    return (p == 2 && e) || (p == 1 && n) || (p == 3 && s);
  endfunction

  // Drive one flit at a falling edge; outputs are sampled at the next falling edge.
  task automatic sendFlit(input logic v, input logic hd, input logic tl, input int mode,
                          input int dx, input int dy, input int p, input logic [4*HW-1:0] h);
    inValid = v; inHead = hd; inTail = tl; routeMode = mode[0];
    destX = dx[1:0]; destY = dy[1:0]; inPort = p[2:0]; congHint = h;
    @(negedge clk);
    inValid = 1'b0; inHead = 1'b0; inTail = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4*HW-1:0] hints [3];
    string tag;
    int exp;
    hints[0] = {4'd5, 4'd5, 4'd5, 4'd5};   // W S E N all equal: tie
    hints[1] = {4'd5, 4'd5, 4'd1, 4'd5};   // east cheaper
    hints[2] = {4'd2, 4'd2, 4'd9, 4'd2};   // Y cheaper

    repeat (3) @(negedge clk);
    check("R1 reset outValid", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(outValid), 0);
    // R1/R3: body with no packet open is dropped
    sendFlit(1'b1, 1'b0, 1'b0, 0, 3, 3, 2, hints[0]);
    check("R1 orphan body dropped", int'(outValid), 0);

    // Sweep modes, destinations, legal carried ports and hint patterns.
    for (int m = 0; m < 2; m++)
      for (int dx = 0; dx < MX; dx++)
        for (int dy = 0; dy < MY; dy++)
          for (int p = 0; p < 5; p++)
            for (int hi = 0; hi < 3; hi++) begin
              if (!legalPort(m, dx, dy, p)) continue;
              if (m == 0 && hi > 0) continue;
              sendFlit(1'b1, 1'b1, 1'b1, m, dx, dy, p, hints[hi]);
              exp = expectNext(m, dx, dy, p, hints[hi]);
              check("R2 head valid", int'(outValid && outHead), 1);
              check("R2 carried port", int'(outPort), p);
              if (p == 0) tag = "R8 local stays local";
              else if (exp == 0) tag = "R4 neighbour is destination";
              else if (m == 0) tag = "R5 dimension order";
              else if (hi > 0 && dx > RX + (p == 2 ? 1 : 0) && dy != RY + (p == 1 ? 1 : 0) - (p == 3 ? 1 : 0))
                tag = "R7 adaptive choice";
              else tag = "R6 west-first";
              check(tag, int'(outNextPort), exp);
              if (p != 0)
                check("R9 no reversal", int'(outNextPort == oppositeOf(p)[2:0]), 0);
            end

    // R7: explicit tie goes to east. Dest (3,0) via east from (1,2): neighbour (2,2).
    sendFlit(1'b1, 1'b1, 1'b1, 1, 3, 0, 2, hints[0]);
    check("R7 tie picks east", int'(outNextPort), 2);
    sendFlit(1'b1, 1'b1, 1'b1, 1, 3, 0, 2, hints[2]);
    check("R7 cheaper south wins", int'(outNextPort), 3);

    // R3: multi-flit packet, body and tail reuse head ports, body after tail dropped.
    sendFlit(1'b1, 1'b1, 1'b0, 0, 3, 3, 2, hints[0]);
    check("R3 head next", int'(outNextPort), 2);
    sendFlit(1'b1, 1'b0, 1'b0, 1, 0, 0, 4, hints[1]);
    check("R3 body valid", int'(outValid && !outHead), 1);
    check("R3 body port", int'(outPort), 2);
    check("R3 body next", int'(outNextPort), 2);
    sendFlit(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, hints[0]);
    check("R3 gap no output", int'(outValid), 0);
    sendFlit(1'b1, 1'b0, 1'b1, 0, 0, 0, 4, hints[0]);
    check("R3 tail valid", int'(outValid && outTail), 1);
    check("R3 tail port", int'(outPort), 2);
    check("R3 tail next", int'(outNextPort), 2);
    sendFlit(1'b1, 1'b0, 1'b0, 0, 0, 0, 4, hints[0]);
    check("R3 body after tail dropped", int'(outValid), 0);
    check("R3 ports held after drop", int'(outPort), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule